// File: doc/BRIEF.md
# Buffered Down-Counting Timer Channel

This block is one channel of a multi-channel timer. Software writes a period value into a count buffer and a threshold into a compare buffer. It then controls the channel through a packed control word that holds fields for five channels. The channel takes only its own field from that word. It counts down a live counter on cycles where a prescaler grants a tick. When the live counter expires, the channel either refills itself from the count buffer or halts. It also drives a pulse-width output that is high while the live count is above the active compare threshold.

Rising edges in the control field do the work. A rising manual-load bit moves both buffers into the working registers. A rising run bit starts the channel and a falling run bit stops it. The channel also clears its own run bit when it halts at expiry. The compare threshold is refreshed from its buffer only at a manual load or an automatic refill, so a change of duty cycle takes effect at a period boundary.

Channel index 4 is a reduced variant. It has no compare path and no output inversion, and its refill-enable bit sits at a fixed position in the word. All inputs are plain register strobes, and a write is taken in the cycle its strobe is high. There is no back-pressure of any kind.

Top module: `tmr_channel`

## Requirements
- R1: After reset the live count, the active compare value and both buffers are 0. The channel field reads 0, so the channel is stopped, and `expire_o` and `pwm_o` are low.
- R2: The channel takes its field from `ctrl_wdata` starting at bit 0 for index 0, and at bit 4·idx+4 for any other index. Within the field, offset 0 is run, 1 is manual load, 2 is invert and 3 is refill-enable. `field_o` returns these bits in that order. For index 4, run is bit 20, manual load is bit 21 and refill-enable is bit 22. Invert always reads 0 for index 4.
- R3: A control write that takes the manual-load bit from 0 to 1 puts the count buffer into the live count, and the compare buffer into the active compare value, in the next cycle. Writing the bit as 1 again while it is already 1 loads nothing.
- R4: A 0→1 write of the run bit starts the channel and a 1→0 write stops it. While running, the live count falls by exactly 1 on each `tick_en` cycle and holds on all other cycles.
- R5: A tick taken while running with a live count of 0 is an expiry. `expire_o` is high for the one cycle after that clock edge. A period therefore lasts N+1 ticks for a buffer value N.
- R6: At expiry with refill-enable set, the live count takes the count buffer, the active compare takes the compare buffer, and the channel keeps running.
- R7: At expiry with refill-enable clear, the run bit in `field_o` is cleared, the channel stops and the live count stays 0.
- R8: `pwm_o` equals (live count > active compare) XOR the invert bit.
- R9: Writes to the count and compare buffers do not change the live count, the active compare value or `pwm_o` until the next load or refill.
- R10: If a manual-load rise falls in the same cycle as a tick, the load wins: there is no decrement and no expiry. If an expiry that halts the channel falls in the same cycle as a control write, the written field is stored with its run bit forced to 0.
- R11: For index 4, `pwm_o` is always 0 and compare-buffer writes have no effect. Expiry and refill follow R5 to R7, with refill-enable taken from bit 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaler tick grant |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 23 | Packed five-channel control word |
| cntbuf_we | input | 1 | Count buffer write strobe |
| cntbuf_wdata | input | CNT_W | Count buffer write value |
| cmpbuf_we | input | 1 | Compare buffer write strobe |
| cmpbuf_wdata | input | CNT_W | Compare buffer write value |
| count_o | output | CNT_W | Live counter (observation value) |
| field_o | output | 4 | Stored field {refill, invert, manual, run} |
| expire_o | output | 1 | One-cycle expiry pulse |
| pwm_o | output | 1 | Pulse-width output |

## Verification
Two functions can land on the same edge: a control write and a tick that either decrements the count or causes an expiry. The bench provokes this in directed form in two ways. First, it raises the manual-load bit while a tick arrives on a zero count. Second, it rewrites the field, with invert set, on the exact tick that halts the channel. It then judges the load-over-tick priority and the forced-clear run bit against a cycle model kept in the bench. Random phases then mix control writes, buffer writes and ticks so that these collisions recur, and every output is compared with the model after every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int TMR_CTRL_W   = 23;
  localparam int TMR_LAST_IDX = 4;
  localparam int TMR_LAST_AR  = 22;

  typedef struct packed {
    logic ar;     // refill-enable
    logic inv;    // output invert
    logic man;    // manual load
    logic start;  // run
  } tmr_field_t;

  function automatic int field_base(input int idx);
    return (idx == 0) ? 0 : 4 * idx + 4;
  endfunction

  function automatic tmr_field_t pick_field(input logic [TMR_CTRL_W-1:0] w,
                                            input int idx);
    tmr_field_t f;
    int b;
    b = field_base(idx);
    f.start = w[b];
    f.man   = w[b+1];
    if (idx == TMR_LAST_IDX) begin
      f.inv = 1'b0;
      f.ar  = w[TMR_LAST_AR];
    end else begin
      f.inv = w[b+2];
      f.ar  = w[b+3];
    end
    return f;
  endfunction

endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
#(
  parameter int CHAN_IDX = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [TMR_CTRL_W-1:0] wr_word,
  input  logic                  stop_req,
  output tmr_field_t            field_q,
  output logic                  load_req
);

  tmr_field_t nf;
  wire        unused_other_bits = ^wr_word;

  always_comb begin
    nf       = pick_field(wr_word, CHAN_IDX);
    load_req = wr_en && nf.man && !field_q.man;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
    end else begin
      if (wr_en)
        field_q <= nf;
      if (stop_req)
        field_q.start <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic             load,
  input  logic             auto_rl,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count_q,
  output logic             expire_q,
  output logic             reload_evt,
  output logic             stop_req
);

  logic tick;
  logic at_zero;
  logic expire_evt;

  always_comb begin
    tick       = run && tick_en && !load;
    at_zero    = (count_q == '0);
    expire_evt = tick && at_zero;
    reload_evt = expire_evt && auto_rl;
    stop_req   = expire_evt && !auto_rl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= expire_evt;
      if (load)
        count_q <= reload_val;
      else if (reload_evt)
        count_q <= reload_val;
      else if (tick && !at_zero)
        count_q <= count_q - 1'b1;
    end
  end

endmodule

// File: rtl/tmr_cmp_out.sv
module tmr_cmp_out #(
  parameter int CNT_W   = 16,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_we,
  input  logic [CNT_W-1:0] buf_wdata,
  input  logic             latch,
  input  logic [CNT_W-1:0] count,
  input  logic             invert,
  output logic             pwm_o
);

  generate
    if (HAS_CMP) begin : g_cmp
      logic [CNT_W-1:0] cmpbuf_q;
      logic [CNT_W-1:0] cmp_act_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cmpbuf_q  <= '0;
          cmp_act_q <= '0;
        end else begin
          if (buf_we)
            cmpbuf_q <= buf_wdata;
          if (latch)
            cmp_act_q <= cmpbuf_q;
        end
      end

      assign pwm_o = (count > cmp_act_q) ^ invert;
    end else begin : g_nocmp
      wire unused_cmp_in = ^{clk, rst_n, buf_we, buf_wdata, latch, count, invert};
      assign pwm_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CHAN_IDX = 1,
  parameter int CNT_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  ctrl_we,
  input  logic [TMR_CTRL_W-1:0] ctrl_wdata,
  input  logic                  cntbuf_we,
  input  logic [CNT_W-1:0]      cntbuf_wdata,
  input  logic                  cmpbuf_we,
  input  logic [CNT_W-1:0]      cmpbuf_wdata,
  output logic [CNT_W-1:0]      count_o,
  output logic [3:0]            field_o,
  output logic                  expire_o,
  output logic                  pwm_o
);

  localparam bit HAS_CMP = (CHAN_IDX != TMR_LAST_IDX);

  logic [CNT_W-1:0] cntbuf_q;
  tmr_field_t       field_q;
  logic             load_req;
  logic             stop_req;
  logic             reload_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cntbuf_q <= '0;
    else if (cntbuf_we)
      cntbuf_q <= cntbuf_wdata;
  end

  tmr_ctrl_reg #(.CHAN_IDX(CHAN_IDX)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctrl_we),
    .wr_word  (ctrl_wdata),
    .stop_req (stop_req),
    .field_q  (field_q),
    .load_req (load_req)
  );

  tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (field_q.start),
    .tick_en    (tick_en),
    .load       (load_req),
    .auto_rl    (field_q.ar),
    .reload_val (cntbuf_q),
    .count_q    (count_o),
    .expire_q   (expire_o),
    .reload_evt (reload_evt),
    .stop_req   (stop_req)
  );

  tmr_cmp_out #(.CNT_W(CNT_W), .HAS_CMP(HAS_CMP)) u_pwm (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_we    (cmpbuf_we),
    .buf_wdata (cmpbuf_wdata),
    .latch     (load_req || reload_evt),
    .count     (count_o),
    .invert    (field_q.inv),
    .pwm_o     (pwm_o)
  );

  assign field_o = field_q;

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             ctrl_we,
  input logic [CNT_W-1:0] count_o,
  input logic [3:0]       field_o,
  input logic             expire_o,
  input logic [CNT_W-1:0] cntbuf_q
);

  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (field_o[0] && tick_en && !ctrl_we && count_o != '0)
      |=> (count_o == $past(count_o) - 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ctrl_we) |=> $stable(count_o));

  p_expire_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> ($past(tick_en) && $past(field_o[0]) && $past(count_o) == '0));

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (field_o[0] && field_o[3] && tick_en && !ctrl_we && count_o == '0)
      |=> (count_o == $past(cntbuf_q) && field_o[0] && expire_o));

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (field_o[0] && !field_o[3] && tick_en && !ctrl_we && count_o == '0)
      |=> (!field_o[0] && count_o == '0 && expire_o));

endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .ctrl_we  (ctrl_we),
  .count_o  (count_o),
  .field_o  (field_o),
  .expire_o (expire_o),
  .cntbuf_q (cntbuf_q)
);

// File: tb/tmr_channel_tb_top.sv
module tmr_channel_tb_top;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          ctrl_we = 1'b0;
  logic [22:0]   ctrl_wdata = '0;
  logic          cntbuf_we = 1'b0;
  logic [CW-1:0] cntbuf_wdata = '0;
  logic          cmpbuf_we = 1'b0;
  logic [CW-1:0] cmpbuf_wdata = '0;
  logic [CW-1:0] count_o;
  logic [3:0]    field_o;
  logic          expire_o;
  logic          pwm_o;

  logic          t4_tick = 1'b0;
  logic          t4_we = 1'b0;
  logic [22:0]   t4_word = '0;
  logic          t4_cwe = 1'b0;
  logic [CW-1:0] t4_cdata = '0;
  logic          t4_mwe = 1'b0;
  logic [CW-1:0] t4_mdata = '0;
  logic [CW-1:0] t4_count;
  logic [3:0]    t4_field;
  logic          t4_exp;
  logic          t4_pwm;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  tmr_channel #(.CHAN_IDX(1), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .cntbuf_we(cntbuf_we), .cntbuf_wdata(cntbuf_wdata),
    .cmpbuf_we(cmpbuf_we), .cmpbuf_wdata(cmpbuf_wdata), .count_o(count_o),
    .field_o(field_o), .expire_o(expire_o), .pwm_o(pwm_o));

  tmr_channel #(.CHAN_IDX(4), .CNT_W(CW)) dut4_i (
    .clk(clk), .rst_n(rst_n), .tick_en(t4_tick), .ctrl_we(t4_we),
    .ctrl_wdata(t4_word), .cntbuf_we(t4_cwe), .cntbuf_wdata(t4_cdata),
    .cmpbuf_we(t4_mwe), .cmpbuf_wdata(t4_mdata), .count_o(t4_count),
    .field_o(t4_field), .expire_o(t4_exp), .pwm_o(t4_pwm));

  // Cycle model of channel index 1 (field at bits 11:8)
  logic [CW-1:0] m_cnt, m_cmp, m_cb, m_mb;
  logic [3:0]    m_fld;
  logic          m_exp;

  function automatic logic [3:0] fld1(input logic [22:0] w);
    return w[11:8];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_cmp <= '0; m_cb <= '0; m_mb <= '0;
      m_fld <= '0; m_exp <= 1'b0;
    end else begin : mdl
      logic [3:0] nf;
      logic mr, tk, ex;
      nf = ctrl_we ? fld1(ctrl_wdata) : m_fld;
      mr = ctrl_we && nf[1] && !m_fld[1];
      tk = m_fld[0] && tick_en && !mr;
      ex = tk && (m_cnt == '0);
      m_exp <= ex;
      if (mr) begin
        m_cnt <= m_cb; m_cmp <= m_mb;
      end else if (ex && m_fld[3]) begin
        m_cnt <= m_cb; m_cmp <= m_mb;
      end else if (tk && m_cnt != '0) begin
        m_cnt <= m_cnt - 1'b1;
      end
      if (ex && !m_fld[3]) nf[0] = 1'b0;
      m_fld <= nf;
      if (cntbuf_we) m_cb <= cntbuf_wdata;
      if (cmpbuf_we) m_mb <= cmpbuf_wdata;
    end
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic ep;
    ep = (m_cnt > m_cmp) ^ m_fld[2];
    chk(count_o == m_cnt, tag, "count", count_o, m_cnt);
    chk(field_o == m_fld, tag, "field", field_o, m_fld);
    chk(expire_o == m_exp, tag, "expire", expire_o, m_exp);
    chk(pwm_o == ep, tag, "pwm", pwm_o, ep);
  endtask

  // advance one clock, compare at the falling edge, release strobes
  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
    ctrl_we = 1'b0; cntbuf_we = 1'b0; cmpbuf_we = 1'b0; tick_en = 1'b0;
    t4_we = 1'b0; t4_cwe = 1'b0; t4_mwe = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [22:0] w);
    ctrl_we = 1'b1; ctrl_wdata = w;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=%0d expected=<60000", cyc);
      finish_run();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7321);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(count_o == 0 && field_o == 0, "R1", "count/field", count_o, 0);
    chk(expire_o == 0 && pwm_o == 0, "R1", "expire/pwm", {expire_o, pwm_o}, 0);
    check_all("R1");

    // R9 buffer writes leave live state alone
    cntbuf_we = 1'b1; cntbuf_wdata = 8'd5; cmpbuf_we = 1'b1; cmpbuf_wdata = 8'd2;
    step("R9");
    chk(count_o == 0 && pwm_o == 0, "R9", "count after buffer write", count_o, 0);

    // R3 manual-load rise; repeated high write does not reload
    wr_ctrl(23'h000200);
    step("R3");
    chk(count_o == 5, "R3", "count after load", count_o, 5);
    cntbuf_we = 1'b1; cntbuf_wdata = 8'd7;
    step("R9");
    wr_ctrl(23'h000200);
    step("R3");
    chk(count_o == 5, "R3", "no reload on level", count_o, 5);

    // R2 field position, R4 run/tick
    wr_ctrl(23'h000300);
    step("R2");
    chk(field_o == 4'b0011, "R2", "field bits", field_o, 3);
    tick_en = 1'b1;
    step("R4");
    chk(count_o == 4, "R4", "decrement", count_o, 4);
    step("R4");
    chk(count_o == 4, "R4", "hold without tick", count_o, 4);
    chk(pwm_o == 1'b1, "R8", "pwm above compare", pwm_o, 1);
    wr_ctrl(23'h000700);
    step("R8");
    chk(pwm_o == 1'b0, "R8", "pwm inverted", pwm_o, 0);

    // R5/R7 expiry without refill
    wr_ctrl(23'h000100);
    step("R7");
    for (int i = 0; i < 5; i++) begin tick_en = 1'b1; step("R5"); end
    chk(expire_o == 1'b1, "R5", "expire pulse", expire_o, 1);
    chk(field_o[0] == 1'b0, "R7", "run bit cleared", field_o[0], 0);
    tick_en = 1'b1;
    step("R5");
    chk(expire_o == 1'b0 && count_o == 0, "R5", "pulse width/count", count_o, 0);

    // R6 refill
    cmpbuf_we = 1'b1; cmpbuf_wdata = 8'd3;
    step("R9");
    wr_ctrl(23'h000200);
    step("R3");
    wr_ctrl(23'h000900);
    step("R6");
    for (int i = 0; i < 8; i++) begin tick_en = 1'b1; step("R6"); end
    chk(expire_o == 1'b1 && count_o == 7, "R6", "refill count", count_o, 7);
    chk(field_o[0] == 1'b1, "R6", "still running", field_o[0], 1);

    // R10 load beats tick at zero count
    for (int i = 0; i < 7; i++) begin tick_en = 1'b1; step("R4"); end
    chk(count_o == 0, "R10", "setup zero", count_o, 0);
    tick_en = 1'b1; wr_ctrl(23'h000300);
    step("R10");
    chk(count_o == 7 && expire_o == 1'b0, "R10", "load wins", count_o, 7);
    // R10 halting expiry coincides with control write
    for (int i = 0; i < 7; i++) begin tick_en = 1'b1; step("R4"); end
    tick_en = 1'b1; wr_ctrl(23'h000500);
    step("R10");
    chk(expire_o == 1'b1 && field_o == 4'b0100, "R10", "forced run clear", field_o, 4);

    // R11 channel index 4
    t4_cwe = 1'b1; t4_cdata = 8'd2; t4_mwe = 1'b1; t4_mdata = 8'd0;
    step("R11");
    t4_we = 1'b1; t4_word = 23'h200000;
    step("R11");
    chk(t4_count == 2, "R11", "idx4 load", t4_count, 2);
    t4_we = 1'b1; t4_word = 23'h500000;
    step("R11");
    chk(t4_field == 4'b1001, "R2", "idx4 field", t4_field, 9);
    for (int i = 0; i < 3; i++) begin
      t4_tick = 1'b1;
      step("R11");
      chk(t4_pwm == 1'b0, "R11", "idx4 pwm low", t4_pwm, 0);
    end
    chk(t4_exp == 1'b1 && t4_count == 2, "R11", "idx4 refill", t4_count, 2);
    t4_tick = 1'b0;
    t4_we = 1'b1; t4_word = 23'h7FFFFF;
    step("R11");
    chk(t4_field[2] == 1'b0 && t4_pwm == 1'b0, "R11", "idx4 no invert", t4_field, 11);

    // Random mix with model comparison
    for (int i = 0; i < 4000; i++) begin
      tick_en = ($urandom % 3) != 0;
      if (($urandom % 7) == 0) begin
        wr_ctrl($urandom);
      end
      if (($urandom % 5) == 0) begin cntbuf_we = 1'b1; cntbuf_wdata = $urandom % 12; end
      if (($urandom % 5) == 0) begin cmpbuf_we = 1'b1; cmpbuf_wdata = $urandom % 12; end
      step("R4");
    end

    finish_run();
  end

endmodule